// File: doc/BRIEF.md
# Serial Peripheral Master with Odd/Even Clock Divider

This block runs one full-duplex serial transfer at a time from a host in the system clock domain. The host pulses `start` and presents a transmit word, a word length of 4 to 32 bits and a divider value. The block then lowers the active-low select and drives the serial clock, which idles low. Transmit data leaves most significant bit first on the transmit pin and changes on falling serial-clock edges. Receive data is captured on rising edges. When the transfer ends the block raises select again, pulses `done` for one cycle and shows the received word on `rx_word`.

The divider sets the serial-clock period to one cycle more than the effective divider value. An odd divider gives equal high and low phases. An even divider makes the high phase one cycle longer than the low phase. A divider of zero is treated as one. Select falls one full serial period before the first rising edge. It stays low for one low phase after the last falling edge. The transmit pin is released to high impedance at that last falling edge.

The controller is a five-state machine. `ST_IDLE` moves to `ST_LEAD` on `start`. `ST_LEAD` moves to `ST_HIGH` after one period. `ST_HIGH` moves to `ST_LOW` while bits remain, or to `ST_TAIL` after bit 0. `ST_LOW` moves back to `ST_HIGH`. `ST_TAIL` moves to `ST_IDLE` after one low phase, and `done` fires on that transition.

Top module: `spi_ser_master`

## Requirements
- R1: With effective divider D, successive rising edges of `sclk` are D+1 system cycles apart.
- R2: For even D, `sclk` stays high for D/2+1 cycles and low for D/2 cycles.
- R3: For odd D, `sclk` stays high and low for (D+1)/2 cycles each.
- R4: Outside a transfer `sel_n` is 1, `sclk` is 0 and `mosi_oe` is 0; `sclk` is never high while `sel_n` is 1.
- R5: `sel_n` falls exactly D+1 cycles before the first rising edge of `sclk`, and bit n-1 is on `mosi` with `mosi_oe`=1 from the cycle `sel_n` falls.
- R6: `mosi` carries bits n-1 down to 0 of `tx_word`, one per serial period, and changes only when `sclk` falls; it is stable while `sclk` is high.
- R7: At the last falling edge `mosi_oe` drops to 0; `sel_n` stays 0 for one low phase more and then rises.
- R8: `miso` is sampled on each rising edge of `sclk`. `done` is high for exactly one cycle, in the cycle `sel_n` rises. `rx_word` then holds the n received bits right-aligned, first bit received as bit n-1, with the upper bits 0.
- R9: `len` values below 4 act as 4 and values above 32 act as 32. Exactly n rising edges occur per transfer, and only the low n bits of `tx_word` are sent.
- R10: A `start` pulse during a transfer is ignored. The running transfer keeps its edge count and data, and no new transfer follows.
- R11: A `div` value of 0 behaves like 1, so the period is 2 cycles with 1 cycle high and 1 cycle low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| len | input | 6 | Word length in bits, clamped to 4..32 |
| div | input | 8 | Serial clock divider value |
| tx_word | input | 32 | Word to send, right-aligned |
| rx_word | output | 32 | Last received word, right-aligned |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk | output | 1 | Serial clock, idles low |
| sel_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial transmit data |
| mosi_oe | output | 1 | Transmit output enable; 0 means high impedance |
| miso | input | 1 | Serial receive data |

## Verification
The assertions assume that reset is applied before the first request. They place no condition on `miso`, and `start`, `len`, `div` and `tx_word` may change at any time, because the block latches them when a transfer begins. The stimulus gives each request as a single-cycle `start` from idle. A slave model changes `miso` only when select falls or `sclk` falls. Random word lengths are drawn partly outside the 4..32 range to reach the clamp. Some transfers get an extra `start` part-way through.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } spim_state_e;
endpackage

// File: rtl/spim_phase_len.sv
// Phase lengths (minus one) of the serial clock for a latched effective divider.
module spim_phase_len #(
    parameter int DIVW = 8
) (
    input  logic [DIVW-1:0] eff_div,
    output logic [DIVW-1:0] hi_m1,
    output logic [DIVW-1:0] lo_m1
);
    always_comb begin
        // even: high = D/2+1, low = D/2 ; odd: both (D+1)/2
        hi_m1 = eff_div >> 1;
        if (eff_div[0]) begin
            lo_m1 = eff_div >> 1;
        end else begin
            lo_m1 = (eff_div >> 1) - DIVW'(1);
        end
    end
endmodule

// File: rtl/spim_shift.sv
// Transmit and receive shift registers, MSB first.
module spim_shift #(
    parameter int MAXW = 32,
    parameter int LENW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MAXW-1:0] tx_word,
    input  logic [LENW-1:0] len_eff,
    input  logic            adv,
    input  logic            capt,
    input  logic            miso,
    output logic            tx_bit,
    output logic [MAXW-1:0] rx_bits
);
    logic [MAXW-1:0] tx_sh;
    logic [MAXW-1:0] rx_sh;
    logic [LENW-1:0] pad;

    assign pad     = LENW'(MAXW) - len_eff;
    assign tx_bit  = tx_sh[MAXW-1];
    assign rx_bits = rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load) begin
                tx_sh <= tx_word << pad;
                rx_sh <= '0;
            end else begin
                if (adv) begin
                    tx_sh <= {tx_sh[MAXW-2:0], 1'b0};
                end
                if (capt) begin
                    rx_sh <= {rx_sh[MAXW-2:0], miso};
                end
            end
        end
    end
endmodule

// File: rtl/spi_ser_master.sv
module spi_ser_master
    import spim_pkg::*;
#(
    parameter int MAXW = 32,
    parameter int MINW = 4,
    parameter int DIVW = 8,
    parameter int LENW = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LENW-1:0] len,
    input  logic [DIVW-1:0] div,
    input  logic [MAXW-1:0] tx_word,
    output logic [MAXW-1:0] rx_word,
    output logic            done,
    output logic            sclk,
    output logic            sel_n,
    output logic            mosi,
    output logic            mosi_oe,
    input  logic            miso
);
    spim_state_e     st, nxt;
    logic [DIVW-1:0] cnt;
    logic [LENW-1:0] bits_left;
    logic [DIVW-1:0] div_q;
    logic [DIVW-1:0] eff_in;
    logic [LENW-1:0] len_c;
    logic [DIVW-1:0] hi_m1, lo_m1;
    logic            tx_bit;
    logic [MAXW-1:0] rx_bits;
    logic            go, adv, capt;

    assign eff_in = (div == '0) ? DIVW'(1) : div;
    assign len_c  = (len < LENW'(MINW)) ? LENW'(MINW) :
                    (len > LENW'(MAXW)) ? LENW'(MAXW) : len;

    assign go   = (st == ST_IDLE) && start;
    assign adv  = (st == ST_HIGH) && (nxt == ST_LOW);
    assign capt = (nxt == ST_HIGH) && (st != ST_HIGH);

    spim_phase_len #(.DIVW(DIVW)) u_phase (
        .eff_div (div_q),
        .hi_m1   (hi_m1),
        .lo_m1   (lo_m1)
    );

    spim_shift #(.MAXW(MAXW), .LENW(LENW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go),
        .tx_word (tx_word),
        .len_eff (len_c),
        .adv     (adv),
        .capt    (capt),
        .miso    (miso),
        .tx_bit  (tx_bit),
        .rx_bits (rx_bits)
    );

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (start)    nxt = ST_LEAD;
            ST_LEAD: if (cnt == '0) nxt = ST_HIGH;
            ST_HIGH: if (cnt == '0) nxt = (bits_left == '0) ? ST_TAIL : ST_LOW;
            ST_LOW:  if (cnt == '0) nxt = ST_HIGH;
            ST_TAIL: if (cnt == '0) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register with phase counter and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            bits_left <= '0;
            div_q     <= DIVW'(1);
        end else begin
            st <= nxt;
            if (go) begin
                div_q     <= eff_in;
                cnt       <= eff_in;
                bits_left <= len_c - LENW'(1);
            end else if (nxt != st) begin
                unique case (nxt)
                    ST_HIGH: cnt <= hi_m1;
                    ST_LOW:  cnt <= lo_m1;
                    ST_TAIL: cnt <= lo_m1;
                    default: cnt <= '0;
                endcase
                if (adv) bits_left <= bits_left - LENW'(1);
            end else if (cnt != '0) begin
                cnt <= cnt - DIVW'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk    <= 1'b0;
            sel_n   <= 1'b1;
            mosi_oe <= 1'b0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            sclk    <= (nxt == ST_HIGH);
            sel_n   <= (nxt == ST_IDLE);
            mosi_oe <= (nxt == ST_LEAD) || (nxt == ST_HIGH) || (nxt == ST_LOW);
            done    <= (st == ST_TAIL) && (nxt == ST_IDLE);
            if ((st == ST_TAIL) && (nxt == ST_IDLE)) rx_word <= rx_bits;
        end
    end

    assign mosi = mosi_oe & tx_bit;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (!sclk && !mosi_oe)); // R4
    AST_SEL_LEADS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(!sel_n)); // R5
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R6
    AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mosi_oe) |-> (!sclk && !sel_n)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(sel_n))); // R8
endmodule

// File: tb/spi_ser_master_bench.sv
module spi_ser_master_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  len = 6'd8;
    logic [7:0]  div = 8'd1;
    logic [31:0] tx_word = '0;
    logic [31:0] rx_word;
    logic        done, sclk, sel_n, mosi, mosi_oe;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_ser_master u_spi_ser_master (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len), .div(div),
        .tx_word(tx_word), .rx_word(rx_word), .done(done), .sclk(sclk),
        .sel_n(sel_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_of(input int d);
        return (d == 0) ? 1 : d;
    endfunction
    function automatic int hi_of(input int d);
        int e = eff_of(d);
        return (e % 2 == 0) ? e / 2 + 1 : (e + 1) / 2;
    endfunction
    function automatic int lo_of(input int d);
        int e = eff_of(d);
        return (e % 2 == 0) ? e / 2 : (e + 1) / 2;
    endfunction
    function automatic int clamp_len(input int n);
        return (n < 4) ? 4 : ((n > 32) ? 32 : n);
    endfunction

    // One transfer, called right after a falling clock edge.
    task automatic run_xfer(input int n_req, input int dv, input logic [31:0] tx,
                            input logic [31:0] slv, input int poke);
        int n = clamp_len(n_req);
        int d = eff_of(dv);
        int hl = hi_of(dv);
        int ll = lo_of(dv);
        longint mask = (64'd1 << n) - 1;
        string rq = (d % 2 == 0) ? "R2" : "R3";
        int first_rise = -1, second_rise = -1, rises = 0;
        int hi_start = -1, lo_start = -1, last_fall = -1;
        int bad_hi = 0, bad_lo = 0, bad_idle = 0, bad_oe = 0, bad_first = 0;
        int done_k = -1, done_cnt = 0, sel_rise = -1, late_sel = 0;
        int sidx = n - 1;
        logic prev = 1'b0;
        logic [31:0] got = '0;
        int k = 0;
        len = 6'(n_req); div = 8'(dv); tx_word = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (k < 20000) begin
            if (k == 0) begin
                if (sel_n !== 1'b0 || mosi_oe !== 1'b1 || mosi !== tx[n-1]) bad_first++;
                miso = slv[n-1];
            end
            if (sel_n && sclk) bad_idle++;
            if (sclk && !prev) begin
                rises++;
                got = {got[30:0], mosi};
                if (first_rise < 0) first_rise = k;
                else if (second_rise < 0) second_rise = k;
                if (lo_start >= 0 && (k - lo_start) != ll) bad_lo++;
                hi_start = k;
            end
            if (!sclk && prev) begin
                if ((k - hi_start) != hl) bad_hi++;
                lo_start = k;
                last_fall = k;
                sidx--;
                if (sidx >= 0) miso = slv[sidx];
                if (rises >= n && mosi_oe !== 1'b0) bad_oe++;
            end
            if (done) begin done_k = k; done_cnt++; end
            if (sel_n && sel_rise < 0 && k > 0) sel_rise = k;
            if (done_k >= 0 && k > done_k && !sel_n) late_sel++;
            prev = sclk;
            if (done_k >= 0 && k >= done_k + 3) break;
            @(negedge clk);
            k++;
            start = (k == poke);
        end
        start = 1'b0;
        chk(done_k >= 0, "R8", "transfer completed", done_k, 0);
        chk(bad_first == 0, "R5", "select and first bit at start", bad_first, 0);
        chk(first_rise == d + 1, (dv == 0) ? "R11" : "R5", "select lead before first rise",
            first_rise, d + 1);
        if (n > 1) chk(second_rise - first_rise == d + 1, "R1", "serial period",
                       second_rise - first_rise, d + 1);
        chk(bad_hi == 0 && bad_lo == 0, rq, "high/low phase widths", bad_hi + bad_lo, 0);
        chk(bad_idle == 0, "R4", "no clock while deselected", bad_idle, 0);
        chk(rises == n, (poke >= 0) ? "R10" : "R9", "rising edge count", rises, n);
        chk((longint'(got) & mask) == (longint'(tx) & mask), "R6", "bits on mosi",
            longint'(got) & mask, longint'(tx) & mask);
        chk(bad_oe == 0 && sel_rise == last_fall + ll, "R7", "tail and release",
            sel_rise, last_fall + ll);
        chk(done_cnt == 1 && done_k == sel_rise, "R8", "done pulse", done_k, sel_rise);
        chk(longint'(rx_word) == (longint'(slv) & mask), "R8", "received word",
            rx_word, longint'(slv) & mask);
        if (poke >= 0) chk(late_sel == 0, "R10", "no transfer after ignored start", late_sel, 0);
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(sel_n === 1'b1 && sclk === 1'b0 && mosi_oe === 1'b0 && done === 1'b0,
            "R4", "reset state", {sel_n, sclk, mosi_oe, done}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_xfer(8, 0, 32'hA5, 32'h3C, -1);               // R11
        run_xfer(8, 1, 32'h5A, 32'hC3, -1);               // R3
        run_xfer(12, 2, 32'h9F1, 32'h246, -1);            // R2
        run_xfer(16, 5, 32'hBEEF, 32'h1234, -1);          // R3
        run_xfer(32, 255, 32'hDEADBEEF, 32'hCAFEF00D, -1);// R1
        run_xfer(4, 4, 32'hF9, 32'hE6, -1);               // R9 low n bits only
        run_xfer(2, 3, 32'h6, 32'hB, -1);                 // R9 clamp up
        run_xfer(40, 1, 32'h8000_0001, 32'h7FFF_FFFE, -1);// R9 clamp down
        run_xfer(10, 6, 32'h2AA, 32'h155, 30);            // R10
        for (int i = 0; i < 24; i++) begin
            int nr = int'($urandom_range(0, 40));
            int dr = int'($urandom_range(0, 20));
            logic [31:0] t = $urandom();
            logic [31:0] s = $urandom();
            int pk = (i % 4 == 0) ? int'($urandom_range(1, 40)) : -1;
            run_xfer(nr, dr, t, s, pk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule